// File: doc/BRIEF.md
# Front panel examine jam sequencer

This block lets a front panel make a halted 8080-class processor jump to an address held on sixteen switch inputs. It does this without touching the processor's registers. When the processor is halted, an examine request takes over the processor's bidirectional data bus. The block raises ready and disables the CPU board's own input buffers. It then feeds the processor one byte per bus cycle: the unconditional-jump opcode C3h, then the low half of the switch word, then the high half. Each bus cycle is marked by a PSYNC pulse. When the fourth cycle begins, which is the instruction fetch at the new address, ready drops and the processor halts again.

Two shorter variants share the same machinery. Examine-next feeds a single no-operation opcode (00h), so the program counter advances by one. In stream mode, the examine request feeds no-operation opcodes cycle after cycle. The run stops at the first PSYNC where the processor's address output equals the switch word, so the processor steps up to that address one location at a time.

The bus driver is enabled only after the buffer-disable signal has been low for a set number of clocks, and only while the processor is reading (DBIN high). This keeps the two drivers from ever fighting over the bus. All outputs are registered, and there is one clock of latency from the input to the pin.

Top module: `exam_jam_seq`

## Requirements
- R1: After a synchronous reset, `ss_n`=1, `xrdy`=0, `bus_oe`=0 and `bus_dout`=00h.
- R2: A request is accepted only while the block is idle and `stopped`=1. On the clock edge that samples an accepted request, `ss_n` goes to 0 and `xrdy` goes to 1. A request made while `stopped`=0 has no effect.
- R3: The examine request with `stream_mode`=0 presents three bytes on `bus_dout`, in this order: C3h, then `sw[7:0]`, then `sw[15:8]`. The block moves on to the next byte on the edge that samples `psync`=1.
- R4: During a jump sequence, `xrdy` stays 1 and `ss_n` stays 0 through all three bytes. On the edge that samples `psync`=1 while the third byte is presented, `xrdy` goes to 0, `ss_n` goes to 1 and `bus_oe` goes to 0.
- R5: `bus_oe` is 1 only when two conditions hold. First, at least OE_DLY clock edges have passed since acceptance, counting the acceptance edge as zero. Second, the same edge sampled `dbin`=1. `bus_oe` is never 1 while `ss_n` is 1.
- R6: The examine-next request presents 00h for a single cycle and ends on the first edge that samples `psync`=1.
- R7: The examine request with `stream_mode`=1 presents 00h. It stays active across PSYNC pulses until an edge samples `psync`=1 with `cpu_addr` equal to `sw`, and it ends on that edge.
- R8: While a sequence is active, both request inputs are ignored. The presented byte and the position in the sequence stay unchanged.
- R9: If both requests are sampled on the same accepting edge, the examine request is taken.
- R10: While the block is idle, `bus_dout` is 00h and `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psync | input | 1 | One-clock pulse marking the start of a processor bus cycle |
| dbin | input | 1 | Processor is reading the data bus |
| stopped | input | 1 | Processor is in stop mode |
| exam_req | input | 1 | Examine request pulse |
| next_req | input | 1 | Examine-next request pulse |
| stream_mode | input | 1 | Examine feeds a no-operation stream instead of a jump |
| sw | input | 16 | Switch word, the target address |
| cpu_addr | input | 16 | Processor address bus |
| bus_dout | output | 8 | Byte to drive onto the processor data bus |
| bus_oe | output | 1 | Data bus drive enable |
| ss_n | output | 1 | CPU-board input buffer disable, active low |
| xrdy | output | 1 | Ready to the processor |

## Verification
The bench checks that the jump bytes appear in order and move on only with PSYNC. A design that advanced on DBIN, or that skipped a stage, would present the high address byte early. It would also drop ready one cycle too soon. The bench checks the first clock at which the drive enable may rise, and repeats the check after the data bus was read with DBIN low. An off-by-one in the delay counter would make the bus driver and the CPU board's buffers overlap. The bench also sends requests while the processor is running and while a sequence is active, sends both requests on the same clock, and runs a stream that has to pass an address that does not match before it stops. A design that compared the address on the wrong PSYNC would stop one location early or one location late.

// File: rtl/exam_jam_pkg.sv
package exam_jam_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  localparam logic [DATA_W-1:0] OPC_JUMP = 8'hC3;
  localparam logic [DATA_W-1:0] OPC_NOP  = 8'h00;

  typedef enum logic [1:0] {
    K_JUMP   = 2'd0,
    K_NEXT   = 2'd1,
    K_STREAM = 2'd2
  } jam_kind_e;

  typedef enum logic [1:0] {
    S_OP = 2'd0,
    S_LO = 2'd1,
    S_HI = 2'd2
  } jam_stage_e;
endpackage

// File: rtl/exam_seq_fsm.sv
module exam_seq_fsm
  import exam_jam_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       psync,
  input  logic       stopped,
  input  logic       exam_req,
  input  logic       next_req,
  input  logic       stream_mode,
  input  logic       addr_hit,
  output logic       accept,
  output logic       nxt_active,
  output jam_kind_e  nxt_kind,
  output jam_stage_e nxt_stage
);
  logic       active;
  jam_kind_e  kind;
  jam_stage_e stage;
  logic       last;

  always_comb begin
    unique case (kind)
      K_JUMP:  last = (stage == S_HI);
      K_NEXT:  last = 1'b1;
      default: last = addr_hit;
    endcase
  end

  always_comb begin
    accept     = !active && stopped && (exam_req || next_req);
    nxt_active = active;
    nxt_kind   = kind;
    nxt_stage  = stage;
    if (accept) begin
      nxt_active = 1'b1;
      nxt_stage  = S_OP;
      if (exam_req) nxt_kind = stream_mode ? K_STREAM : K_JUMP;
      else          nxt_kind = K_NEXT;
    end else if (active && psync) begin
      if (last) begin
        nxt_active = 1'b0;
        nxt_stage  = S_OP;
      end else if (kind == K_JUMP) begin
        nxt_stage = (stage == S_OP) ? S_LO : S_HI;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      kind   <= K_JUMP;
      stage  <= S_OP;
    end else begin
      active <= nxt_active;
      kind   <= nxt_kind;
      stage  <= nxt_stage;
    end
  end

  assert_no_start_running_R2: assert property (@(posedge clk) disable iff (rst)
    (!active && !stopped) |=> !active);

  assert_jump_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (active && kind == K_JUMP && stage == S_HI && psync) |=> !active);

  assert_single_stage_R6: assert property (@(posedge clk) disable iff (rst)
    (active && kind != K_JUMP) |-> stage == S_OP);

  assert_hold_between_sync_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !psync) |=> (active && $stable(stage) && $stable(kind)));
endmodule

// File: rtl/exam_oe_timer.sv
module exam_oe_timer #(
  parameter int OE_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic ripe
);
  localparam int CW = $clog2(OE_DLY + 1);
  localparam logic [CW-1:0] LIM = CW'(OE_DLY);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (!run || restart)  cnt_nxt = '0;
    else if (cnt != LIM)  cnt_nxt = cnt + 1'b1;
    else                  cnt_nxt = cnt;
    ripe = (cnt_nxt == LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  assert_cnt_clears_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/exam_byte_mux.sv
module exam_byte_mux
  import exam_jam_pkg::*;
(
  input  jam_kind_e         kind,
  input  jam_stage_e        stage,
  input  logic [ADDR_W-1:0] sw,
  output logic [DATA_W-1:0] jam_byte
);
  always_comb begin
    jam_byte = OPC_NOP;
    if (kind == K_JUMP) begin
      unique case (stage)
        S_OP:    jam_byte = OPC_JUMP;
        S_LO:    jam_byte = sw[DATA_W-1:0];
        default: jam_byte = sw[ADDR_W-1:DATA_W];
      endcase
    end
  end
endmodule

// File: rtl/exam_jam_seq.sv
module exam_jam_seq
  import exam_jam_pkg::*;
#(
  parameter int OE_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psync,
  input  logic              dbin,
  input  logic              stopped,
  input  logic              exam_req,
  input  logic              next_req,
  input  logic              stream_mode,
  input  logic [ADDR_W-1:0] sw,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              ss_n,
  output logic              xrdy
);
  logic              accept, nxt_active, ripe;
  jam_kind_e         nxt_kind;
  jam_stage_e        nxt_stage;
  logic [DATA_W-1:0] jam_byte;

  exam_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .psync(psync), .stopped(stopped),
    .exam_req(exam_req), .next_req(next_req), .stream_mode(stream_mode),
    .addr_hit(cpu_addr == sw), .accept(accept), .nxt_active(nxt_active),
    .nxt_kind(nxt_kind), .nxt_stage(nxt_stage)
  );

  exam_oe_timer #(.OE_DLY(OE_DLY)) u_timer (
    .clk(clk), .rst(rst), .run(nxt_active), .restart(accept), .ripe(ripe)
  );

  exam_byte_mux u_mux (
    .kind(nxt_kind), .stage(nxt_stage), .sw(sw), .jam_byte(jam_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_n     <= 1'b1;
      xrdy     <= 1'b0;
      bus_oe   <= 1'b0;
      bus_dout <= OPC_NOP;
    end else begin
      ss_n     <= !nxt_active;
      xrdy     <= nxt_active;
      bus_oe   <= nxt_active && ripe && dbin;
      bus_dout <= nxt_active ? jam_byte : OPC_NOP;
    end
  end

  assert_oe_inside_ss_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !ss_n);

  assert_oe_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(dbin));

  assert_start_needs_stop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(xrdy) |-> $past(stopped));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !xrdy |-> (bus_dout == OPC_NOP && !bus_oe));
endmodule

// File: tb/exam_jam_seq_tb.sv
module exam_jam_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst, psync, dbin, stopped, exam_req, next_req, stream_mode;
  logic [15:0] sw, cpu_addr;
  logic [7:0]  bus_dout;
  logic        bus_oe, ss_n, xrdy;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_act = 0;
  int m_kind = 0;   // 0 jump, 1 next, 2 stream
  int m_stage = 0;
  int m_cnt = 0;
  bit e_ss_n = 1, e_xrdy = 0, e_oe = 0;
  logic [7:0] e_dout = 8'h00;

  exam_jam_seq #(.OE_DLY(D)) u_dut (
    .clk(clk), .rst(rst), .psync(psync), .dbin(dbin), .stopped(stopped),
    .exam_req(exam_req), .next_req(next_req), .stream_mode(stream_mode),
    .sw(sw), .cpu_addr(cpu_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .ss_n(ss_n), .xrdy(xrdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit fin;
    cycles++;
    if (rst) begin
      m_act = 0; m_stage = 0; m_cnt = 0;
    end else if (!m_act) begin
      if (stopped && (exam_req || next_req)) begin
        m_act = 1; m_stage = 0; m_cnt = 0;
        m_kind = exam_req ? (stream_mode ? 2 : 0) : 1;
      end
    end else begin
      fin = 0;
      if (psync) begin
        if (m_kind == 1) fin = 1;
        else if (m_kind == 2) fin = (cpu_addr == sw);
        else if (m_stage == 2) fin = 1;
        else m_stage++;
      end
      if (fin) begin m_act = 0; m_stage = 0; m_cnt = 0; end
      else if (m_cnt < D) m_cnt++;
    end
    e_ss_n = !m_act;
    e_xrdy = m_act;
    e_oe = m_act && (m_cnt >= D) && dbin;
    if (!m_act || m_kind != 0) e_dout = 8'h00;
    else if (m_stage == 0) e_dout = 8'hC3;
    else if (m_stage == 1) e_dout = sw[7:0];
    else e_dout = sw[15:8];
    #1;
    check(cur_req, {24'd0, bus_dout}, {24'd0, e_dout}, "model bus_dout");
    check(cur_req, {29'd0, bus_oe, ss_n, xrdy}, {29'd0, e_oe, e_ss_n, e_xrdy}, "model oe/ss_n/xrdy");
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(input bit ps, input bit db);
    @(negedge clk);
    psync = ps; dbin = db;
    @(posedge clk); #2;
    exam_req = 0; next_req = 0;
  endtask

  initial begin
    rst = 1; psync = 0; dbin = 0; stopped = 1; exam_req = 0; next_req = 0;
    stream_mode = 0; sw = 16'hA55A; cpu_addr = 16'h0000;
    repeat (3) step(0, 0);
    @(negedge clk); rst = 0;
    step(0, 0);
    check("R1", {ss_n, xrdy, bus_oe}, 3'b100, "reset outputs");
    check("R10", bus_dout, 8'h00, "idle byte");

    cur_req = "R2";
    stopped = 0; exam_req = 1; step(0, 1);
    check("R2", xrdy, 1'b0, "request while running ignored");
    step(0, 0);
    stopped = 1;

    cur_req = "R3";
    exam_req = 1; step(0, 0);
    check("R2", {ss_n, xrdy}, 2'b01, "accept edge");
    check("R3", bus_dout, 8'hC3, "jump opcode");
    step(0, 1);
    check("R5", bus_oe, 1'b0, "oe early 1");
    step(0, 1);
    check("R5", bus_oe, 1'b0, "oe early 2");
    step(0, 1);
    check("R5", bus_oe, 1'b1, "oe at delay");
    step(0, 0);
    check("R5", bus_oe, 1'b0, "oe follows dbin");
    step(1, 0);
    check("R3", bus_dout, 8'h5A, "low byte");
    check("R4", xrdy, 1'b1, "ready held stage 2");
    next_req = 1; exam_req = 1; step(0, 1);
    check("R8", bus_dout, 8'h5A, "request ignored while active");
    check("R5", bus_oe, 1'b1, "oe in stage 2");
    step(1, 0);
    check("R3", bus_dout, 8'hA5, "high byte");
    check("R4", xrdy, 1'b1, "ready held stage 3");
    step(0, 1);
    step(1, 0);
    check("R4", {ss_n, xrdy, bus_oe}, 3'b100, "stop on fourth sync");
    check("R10", bus_dout, 8'h00, "idle after jump");
    step(0, 0);

    cur_req = "R6";
    next_req = 1; step(0, 0);
    check("R6", {bus_dout, xrdy}, {8'h00, 1'b1}, "next started");
    step(0, 1); step(0, 1); step(0, 1);
    check("R6", bus_oe, 1'b1, "next drives nop");
    step(1, 0);
    check("R6", xrdy, 1'b0, "next ends at sync");
    step(0, 0);

    cur_req = "R7";
    stream_mode = 1; sw = 16'h0102; exam_req = 1; step(0, 0);
    check("R7", {bus_dout, xrdy}, {8'h00, 1'b1}, "stream started");
    cpu_addr = 16'h0101; step(1, 0);
    check("R7", xrdy, 1'b1, "stream continues on miss");
    step(0, 1);
    cpu_addr = 16'h0102; step(1, 0);
    check("R7", xrdy, 1'b0, "stream stops on hit");
    stream_mode = 0; step(0, 0);

    cur_req = "R9";
    sw = 16'h3C4B; exam_req = 1; next_req = 1; step(0, 0);
    check("R9", bus_dout, 8'hC3, "examine wins");
    step(1, 0);
    check("R9", bus_dout, 8'h4B, "jump path taken");
    step(1, 0); step(1, 0);
    check("R4", xrdy, 1'b0, "second jump ends");
    step(0, 0); step(0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule